// File: doc/BRIEF.md
# Asynchronous Serial Port with Selectable Even Parity

This block is the character-level link between a command-driven serial memory and its host. It receives and sends bytes over a single-wire asynchronous line in each direction. All timing comes from one system clock: a divider of `CLK_DIV` clocks sets the length of each bit. Its default of 512 yields 9600 baud from a 4.9152 MHz clock. A strap input, `parity_en`, selects whether each character carries an even parity bit after its data. When the strap is low, the stop bit follows the data bits directly.

A character on the line is a low start bit, eight data bits sent least significant bit first, the optional parity bit, and a high stop bit. The receiver waits in `RX_IDLE` while the line is high, so any run of high bits between characters is treated as idle. A low level moves it to `RX_START`. Half a bit later it checks the line again. If the line is still low it proceeds to `RX_DATA`; otherwise it returns to `RX_IDLE`. After the eighth bit it goes to `RX_PARITY` when parity is enabled, and to `RX_STOP` otherwise. In the middle of the stop bit it returns to `RX_IDLE` and presents the byte with a one-cycle strobe. A parity mismatch sets a sticky error flag.

The transmitter moves from `TX_IDLE` to `TX_START` when a byte is offered while it is ready. It then steps through `TX_DATA`, `TX_PARITY` (only when enabled) and `TX_STOP`, each state lasting whole bits, and returns to `TX_IDLE` with a one-cycle done pulse. Its output enable is high only while a character is on the line, so the pin floats when the transmitter is idle. Holding `cs` low resets both directions and clears the error flag. While the error flag is set, the transmitter is held idle. Interpreting the bytes as commands is left to the surrounding logic.

Top module: `async_link`

## Requirements
- R1: A transmitted character holds each bit for exactly CLK_DIV clocks. The first bit is a low start bit, and it appears on the cycle after `tx_start` is accepted. Eight data bits follow with bit 0 first, and the character ends with a high stop bit.
- R2: With `parity_en` high, a bit equal to the XOR of the eight data bits (even parity) is sent between data bit 7 and the stop bit. With `parity_en` low, no such bit is sent, and `tx_done` rises CLK_DIV/2 clocks after the middle of the stop bit in both settings.
- R3: The receiver assembles eight bits, bit 0 first, and pulses `rx_valid` for one clock with the byte on `rx_data`, once per character.
- R4: When parity is enabled and the received parity bit makes the total count of ones odd, `rx_parity_err` rises. The byte is still delivered, and the flag stays high until `cs` goes low.
- R5: A low level on `rxd` that is gone by the middle of the start bit (CLK_DIV/2 clocks after detection) produces no byte, and the receiver then accepts the next character normally.
- R6: Any number of high bits between characters is ignored. Characters sent back to back, with no idle gap, are all received.
- R7: While `cs` is low, both directions are held in reset. From the next clock on, `tx_oe` is low, `txd` is high, `rx_valid` is low and `rx_parity_err` is clear. A character that was partly received when `cs` fell is discarded.
- R8: `tx_ready` is high only while the transmitter is idle, `cs` is high and no parity error is flagged. A `tx_start` while `tx_ready` is low is ignored and does not alter the character on the line.
- R9: `tx_done` is a one-clock pulse after the stop bit. Whenever `tx_oe` is low, `txd` rests high.
- R10: While `rx_parity_err` is set, the transmitter stays idle: `tx_oe` and `tx_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| cs | input | 1 | Select; low resets and aborts both directions |
| parity_en | input | 1 | High: even parity bit per character; low: none |
| rxd | input | 1 | Serial receive line, idle high |
| rx_data | output | DATA_W | Last received byte |
| rx_valid | output | 1 | One-clock strobe for `rx_data` |
| rx_parity_err | output | 1 | Sticky received-parity mismatch |
| tx_data | input | DATA_W | Byte to send |
| tx_start | input | 1 | Request to send `tx_data` |
| tx_ready | output | 1 | Transmitter can accept a byte |
| tx_done | output | 1 | One-clock pulse after the stop bit |
| txd | output | 1 | Serial transmit line value |
| tx_oe | output | 1 | Drive enable for `txd`; low means high-impedance |

## Verification
The properties assume that `parity_en` changes only while no character is in flight in either direction. They also assume that `tx_data` is stable in the cycle `tx_start` is accepted. The directed stimulus changes the strap only between scenarios, when both lines are idle. It drives `rxd` only at whole multiples of the bit time, apart from the deliberate short glitch. The bench shortens the divider to 16 so that many characters fit in a short run. It samples the transmit line at each bit midpoint, as computed from the acceptance edge.

// File: rtl/async_link_pkg.sv
`timescale 1ns/100ps
package async_link_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_t;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP
    } tx_state_t;

endpackage

// File: rtl/async_link_timer.sv
`timescale 1ns/100ps
// Bit-time counter: wraps every DIV clocks; tick marks the last clock of
// a full bit, or of half a bit when half_mode is set.
module async_link_timer #(
    parameter int DIV = 512
) (
    input  logic clk,
    input  logic clear,
    input  logic half_mode,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 2;
    localparam logic [CW-1:0] FULL_END = CW'(DIV - 1);
    localparam logic [CW-1:0] HALF_END = CW'(DIV / 2 - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (clear) begin
            cnt <= '0;
        end else if (cnt == FULL_END) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        tick = half_mode ? (cnt == HALF_END) : (cnt == FULL_END);
    end
endmodule

// File: rtl/async_link_rx.sv
`timescale 1ns/100ps
module async_link_rx
    import async_link_pkg::*;
#(
    parameter int DIV = 512,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          parity_en,
    input  logic          rxd_s,
    output logic [DW-1:0] data,
    output logic          valid,
    output logic          par_fault
);
    localparam int BW = (DW > 2) ? $clog2(DW) : 2;
    localparam logic [BW-1:0] LAST_IDX = BW'(DW - 1);

    rx_state_t     state, nxt;
    logic [DW-1:0] shreg;
    logic [BW-1:0] idx;
    logic          bad_q;
    logic          tick;
    logic          tclr;
    logic          half_sel;

    assign half_sel = (state == RX_START);
    assign tclr     = rst || (state == RX_IDLE) || (half_sel && tick);

    async_link_timer #(.DIV(DIV)) u_timer (
        .clk       (clk),
        .clear     (tclr),
        .half_mode (half_sel),
        .tick      (tick)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:   if (!rxd_s) nxt = RX_START;
            RX_START:  if (tick) nxt = rxd_s ? RX_IDLE : RX_DATA;
            RX_DATA:   if (tick && idx == LAST_IDX) nxt = parity_en ? RX_PARITY : RX_STOP;
            RX_PARITY: if (tick) nxt = RX_STOP;
            RX_STOP:   if (tick) nxt = RX_IDLE;
            default:   nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RX_IDLE;
            shreg <= '0;
            idx   <= '0;
            bad_q <= 1'b0;
        end else begin
            state <= nxt;
            unique case (state)
                RX_IDLE: begin
                    idx   <= '0;
                    bad_q <= 1'b0;
                end
                RX_DATA: begin
                    if (tick) begin
                        shreg <= {rxd_s, shreg[DW-1:1]};
                        idx   <= idx + 1'b1;
                    end
                end
                RX_PARITY: begin
                    if (tick) bad_q <= ^{shreg, rxd_s};
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        valid     = (state == RX_STOP) && tick;
        par_fault = valid && bad_q;
        data      = shreg;
    end
endmodule

// File: rtl/async_link_tx.sv
`timescale 1ns/100ps
module async_link_tx
    import async_link_pkg::*;
#(
    parameter int DIV = 512,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          halt,
    input  logic          parity_en,
    input  logic [DW-1:0] din,
    input  logic          start,
    output logic          ready,
    output logic          txd,
    output logic          oe,
    output logic          done
);
    localparam int BW = (DW > 2) ? $clog2(DW) : 2;
    localparam logic [BW-1:0] LAST_IDX = BW'(DW - 1);

    tx_state_t     state, nxt;
    logic [DW-1:0] shreg;
    logic [BW-1:0] idx;
    logic          par_q;
    logic          tick;
    logic          tclr;

    assign tclr = halt || (state == TX_IDLE);

    async_link_timer #(.DIV(DIV)) u_timer (
        .clk       (clk),
        .clear     (tclr),
        .half_mode (1'b0),
        .tick      (tick)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:   if (start) nxt = TX_START;
            TX_START:  if (tick) nxt = TX_DATA;
            TX_DATA:   if (tick && idx == LAST_IDX) nxt = parity_en ? TX_PARITY : TX_STOP;
            TX_PARITY: if (tick) nxt = TX_STOP;
            TX_STOP:   if (tick) nxt = TX_IDLE;
            default:   nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (halt) begin
            state <= TX_IDLE;
            shreg <= '0;
            idx   <= '0;
            par_q <= 1'b0;
            done  <= 1'b0;
        end else begin
            state <= nxt;
            done  <= (state == TX_STOP) && tick;
            unique case (state)
                TX_IDLE: begin
                    if (start) begin
                        shreg <= din;
                        par_q <= ^din;
                        idx   <= '0;
                    end
                end
                TX_DATA: begin
                    if (tick) begin
                        shreg <= {1'b0, shreg[DW-1:1]};
                        idx   <= idx + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        ready = (state == TX_IDLE) && !halt;
        oe    = (state != TX_IDLE);
        unique case (state)
            TX_START:  txd = 1'b0;
            TX_DATA:   txd = shreg[0];
            TX_PARITY: txd = par_q;
            default:   txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/async_link.sv
`timescale 1ns/100ps
module async_link #(
    parameter int CLK_DIV = 512,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              cs,
    input  logic              parity_en,
    input  logic              rxd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_parity_err,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_start,
    output logic              tx_ready,
    output logic              tx_done,
    output logic              txd,
    output logic              tx_oe
);
    logic rxd_meta;
    logic rxd_s;
    logic err_q;
    logic fault;
    logic rst;
    logic halt;

    assign rst  = !cs;
    assign halt = rst || err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rxd_meta <= 1'b1;
            rxd_s    <= 1'b1;
            err_q    <= 1'b0;
        end else begin
            rxd_meta <= rxd;
            rxd_s    <= rxd_meta;
            err_q    <= err_q | fault;
        end
    end

    async_link_rx #(.DIV(CLK_DIV), .DW(DATA_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .parity_en (parity_en),
        .rxd_s     (rxd_s),
        .data      (rx_data),
        .valid     (rx_valid),
        .par_fault (fault)
    );

    async_link_tx #(.DIV(CLK_DIV), .DW(DATA_W)) u_tx (
        .clk       (clk),
        .halt      (halt),
        .parity_en (parity_en),
        .din       (tx_data),
        .start     (tx_start),
        .ready     (tx_ready),
        .txd       (txd),
        .oe        (tx_oe),
        .done      (tx_done)
    );

    assign rx_parity_err = err_q;
endmodule

// File: rtl/async_link_checker.sv
`timescale 1ns/100ps
module async_link_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              cs,
    input logic              rx_valid,
    input logic              rx_parity_err,
    input logic [DATA_W-1:0] tx_data,
    input logic              tx_start,
    input logic              tx_ready,
    input logic              tx_done,
    input logic              txd,
    input logic              tx_oe
);
    assert_cs_abort_R7: assert property (@(posedge clk)
        !cs |=> (!tx_oe && !rx_valid && !rx_parity_err));

    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!cs)
        rx_parity_err |=> rx_parity_err);

    assert_err_source_R4: assert property (@(posedge clk) disable iff (!cs)
        $rose(rx_parity_err) |-> $past(rx_valid));

    assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!cs)
        rx_valid |=> !rx_valid);

    assert_start_bit_R1: assert property (@(posedge clk) disable iff (!cs)
        (tx_start && tx_ready) |=> (tx_oe && !txd));

    assert_ready_idle_R8: assert property (@(posedge clk) disable iff (!cs)
        tx_ready |-> !tx_oe);

    assert_idle_mark_R9: assert property (@(posedge clk) disable iff (!cs)
        !tx_oe |-> txd);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!cs)
        tx_done |-> (!tx_oe && !$past(tx_done)));

    assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!cs)
        rx_parity_err |=> (!tx_oe && !tx_ready));

    // tx_data is only meaningful when a start is accepted
    assert_data_known_R1: assert property (@(posedge clk) disable iff (!cs)
        (tx_start && tx_ready) |-> !$isunknown(tx_data));
endmodule

bind async_link async_link_checker #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .cs            (cs),
    .rx_valid      (rx_valid),
    .rx_parity_err (rx_parity_err),
    .tx_data       (tx_data),
    .tx_start      (tx_start),
    .tx_ready      (tx_ready),
    .tx_done       (tx_done),
    .txd           (txd),
    .tx_oe         (tx_oe)
);

// File: tb/async_link_test.sv
`timescale 1ns/100ps
module async_link_test;
    localparam int DIV = 16;
    localparam int DW  = 8;

    logic          clk = 1'b0;
    logic          cs = 1'b0;
    logic          parity_en = 1'b0;
    logic          rxd = 1'b1;
    logic [DW-1:0] rx_data;
    logic          rx_valid;
    logic          rx_parity_err;
    logic [DW-1:0] tx_data = '0;
    logic          tx_start = 1'b0;
    logic          tx_ready;
    logic          tx_done;
    logic          txd;
    logic          tx_oe;

    int checks = 0;
    int fails = 0;
    int rx_count = 0;
    logic [DW-1:0] rx_last = '0;

    always #2.5 clk = ~clk;

    async_link #(.CLK_DIV(DIV), .DATA_W(DW)) uut (
        .clk           (clk),
        .cs            (cs),
        .parity_en     (parity_en),
        .rxd           (rxd),
        .rx_data       (rx_data),
        .rx_valid      (rx_valid),
        .rx_parity_err (rx_parity_err),
        .tx_data       (tx_data),
        .tx_start      (tx_start),
        .tx_ready      (tx_ready),
        .tx_done       (tx_done),
        .txd           (txd),
        .tx_oe         (tx_oe)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            rx_count = rx_count + 1;
            rx_last  = rx_data;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic drive_char(input logic [DW-1:0] b, input logic with_par, input logic flip);
        rxd = 1'b0;
        step(DIV);
        for (int i = 0; i < DW; i++) begin
            rxd = b[i];
            step(DIV);
        end
        if (with_par) begin
            rxd = (^b) ^ flip;
            step(DIV);
        end
        rxd = 1'b1;
        step(DIV);
    endtask

    // sends b and samples every bit at its midpoint; a stray start request
    // with other data is held during the character (R8)
    task automatic tx_capture(input logic [DW-1:0] b, input logic par);
        int n;
        tx_data  = b;
        tx_start = 1'b1;
        step(1);
        tx_start = 1'b0;
        step(DIV / 2);
        chk("R1", "start bit level", {31'd0, txd}, 32'd0);
        chk("R1", "oe during start bit", {31'd0, tx_oe}, 32'd1);
        chk("R8", "ready while busy", {31'd0, tx_ready}, 32'd0);
        tx_data  = ~b;
        tx_start = 1'b1;
        for (int i = 0; i < DW; i++) begin
            step(DIV);
            chk("R1", $sformatf("data bit %0d", i), {31'd0, txd}, {31'd0, b[i]});
        end
        tx_start = 1'b0;
        if (par) begin
            step(DIV);
            chk("R2", "even parity bit", {31'd0, txd}, {31'd0, ^b});
        end
        step(DIV);
        chk("R1", "stop bit level", {31'd0, txd}, 32'd1);
        chk("R1", "oe during stop bit", {31'd0, tx_oe}, 32'd1);
        n = 0;
        while (!tx_done && n < DIV) begin
            step(1);
            n++;
        end
        chk("R2", "done delay after stop midpoint", n, DIV / 2);
        step(1);
        chk("R9", "done is one pulse", {31'd0, tx_done}, 32'd0);
        chk("R9", "oe released when idle", {31'd0, tx_oe}, 32'd0);
        chk("R9", "line rests high", {31'd0, txd}, 32'd1);
        chk("R8", "ready again", {31'd0, tx_ready}, 32'd1);
    endtask

    task automatic test_reset();
        step(3);
        chk("R7", "oe in reset", {31'd0, tx_oe}, 32'd0);
        chk("R7", "valid in reset", {31'd0, rx_valid}, 32'd0);
        chk("R7", "err in reset", {31'd0, rx_parity_err}, 32'd0);
        chk("R8", "not ready in reset", {31'd0, tx_ready}, 32'd0);
        chk("R9", "txd high in reset", {31'd0, txd}, 32'd1);
        cs = 1'b1;
        step(2);
        chk("R8", "ready after select", {31'd0, tx_ready}, 32'd1);
    endtask

    task automatic test_tx_plain();
        parity_en = 1'b0;
        tx_capture(8'hA5, 1'b0);
        tx_capture(8'h01, 1'b0);
    endtask

    task automatic test_tx_parity();
        parity_en = 1'b1;
        tx_capture(8'h37, 1'b1);
        tx_capture(8'hC3, 1'b1);
        parity_en = 1'b0;
    endtask

    task automatic test_rx_basic();
        int c0;
        c0 = rx_count;
        parity_en = 1'b0;
        drive_char(8'h5A, 1'b0, 1'b0);
        chk("R3", "one strobe, no parity", rx_count - c0, 1);
        chk("R3", "byte, no parity", {24'd0, rx_last}, 32'h5A);
        parity_en = 1'b1;
        drive_char(8'h96, 1'b1, 1'b0);
        chk("R3", "one strobe, parity", rx_count - c0, 2);
        chk("R3", "byte, parity", {24'd0, rx_last}, 32'h96);
        chk("R4", "good parity no error", {31'd0, rx_parity_err}, 32'd0);
        parity_en = 1'b0;
        step(DIV);
    endtask

    task automatic test_rx_gaps();
        int c0;
        c0 = rx_count;
        rxd = 1'b1;
        step(3 * DIV + 5);
        chk("R6", "idle ones give nothing", rx_count - c0, 0);
        drive_char(8'h81, 1'b0, 1'b0);
        chk("R6", "first after gap", {24'd0, rx_last}, 32'h81);
        drive_char(8'h7E, 1'b0, 1'b0);
        chk("R6", "back to back count", rx_count - c0, 2);
        chk("R6", "back to back byte", {24'd0, rx_last}, 32'h7E);
        step(DIV);
    endtask

    task automatic test_glitch();
        int c0;
        c0 = rx_count;
        rxd = 1'b0;
        step(DIV / 4);
        rxd = 1'b1;
        step(2 * DIV);
        chk("R5", "short low rejected", rx_count - c0, 0);
        drive_char(8'h3C, 1'b0, 1'b0);
        chk("R5", "receiver alive after glitch", {24'd0, rx_last}, 32'h3C);
        step(DIV);
    endtask

    task automatic test_parity_err();
        int c0;
        c0 = rx_count;
        parity_en = 1'b1;
        drive_char(8'h55, 1'b1, 1'b1);
        chk("R4", "byte still delivered", {24'd0, rx_last}, 32'h55);
        chk("R4", "error raised", {31'd0, rx_parity_err}, 32'd1);
        step(2);
        chk("R10", "oe low on error", {31'd0, tx_oe}, 32'd0);
        chk("R10", "not ready on error", {31'd0, tx_ready}, 32'd0);
        tx_data  = 8'h00;
        tx_start = 1'b1;
        step(3);
        tx_start = 1'b0;
        chk("R10", "start ignored on error", {31'd0, tx_oe}, 32'd0);
        drive_char(8'h12, 1'b1, 1'b0);
        chk("R4", "error sticky", {31'd0, rx_parity_err}, 32'd1);
        chk("R4", "strobes counted", rx_count - c0, 2);
        cs = 1'b0;
        step(2);
        cs = 1'b1;
        step(1);
        chk("R4", "error cleared by select", {31'd0, rx_parity_err}, 32'd0);
        chk("R7", "ready after select pulse", {31'd0, tx_ready}, 32'd1);
        parity_en = 1'b0;
    endtask

    task automatic test_cs_abort();
        int c0;
        tx_data  = 8'hF0;
        tx_start = 1'b1;
        step(1);
        tx_start = 1'b0;
        step(3 * DIV);
        chk("R7", "tx active before abort", {31'd0, tx_oe}, 32'd1);
        cs = 1'b0;
        step(1);
        chk("R7", "oe dropped by select", {31'd0, tx_oe}, 32'd0);
        chk("R7", "txd high after abort", {31'd0, txd}, 32'd1);
        cs = 1'b1;
        step(1);
        chk("R7", "ready after abort", {31'd0, tx_ready}, 32'd1);
        c0 = rx_count;
        rxd = 1'b0;
        step(3 * DIV);
        cs = 1'b0;
        step(2);
        rxd = 1'b1;
        cs = 1'b1;
        step(12 * DIV);
        chk("R7", "partial rx discarded", rx_count - c0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        summary_and_end();
    end

    initial begin
        test_reset();
        test_tx_plain();
        test_tx_parity();
        test_rx_basic();
        test_rx_gaps();
        test_glitch();
        test_parity_err();
        test_cs_abort();
        summary_and_end();
    end
endmodule